// File: doc/BRIEF.md
# Loss-of-Clock Detector

This block watches an externally supplied clock, such as a receive or transmit line clock, and raises a real-time loss-of-clock status when that clock stops toggling. The time without activity is measured with a free-running reference (system) clock rather than with the monitored clock itself. One instance covers one clock, so a design places two copies to cover the receive and transmit clocks.

In the monitored domain a toggle flip-flop inverts on every rising edge. Its value passes through a multi-stage synchroniser into the reference domain. Any change in the synchronised value counts as activity. An idle counter restarts on each activity and saturates at a threshold, and the status is set while the counter sits at that threshold. Reset presets the counter to the threshold, so the status reads asserted until the monitored clock shows that it is running.

Top module: `clk_loss_detect`

## Requirements
- R1: The status `clk_lost` is 1 during reset and on the first reference cycle after reset. It stays 1 for as long as the monitored clock does not toggle.
- R2: While the monitored clock runs with a period between 2 and 10 reference periods, `clk_lost` stays 0 once it has cleared.
- R3: After the last rising edge of the monitored clock, `clk_lost` goes to 1 no earlier than 9 and no later than 21 reference periods after that edge. With the default settings the counter reaches its limit of 16 idle cycles before the status is set.
- R4: Once set, `clk_lost` holds at 1 for any length of time without monitored activity. The idle counter saturates and never wraps.
- R5: When the monitored clock resumes, `clk_lost` returns to 0 within 5 reference periods of the first rising edge. It clears on the first reference cycle after activity is seen.
- R6: After reset is released with the monitored clock already running, `clk_lost` drops to 0 within 6 reference periods.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | 1 | Free-running reference clock used to time inactivity |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| mon_clk | input | 1 | Clock being monitored |
| clk_lost | output | 1 | 1 while the monitored clock is considered absent |

## Verification
The bench builds the detector with its default two synchroniser stages and an idle limit of 16. With these values the onset of the status (about 17 to 19 reference periods after the last edge) falls well inside the 9-to-21 window, so the bench can check the window directly. Monitored periods are drawn at random between 2 and 10 reference periods, using non-integer phases so that edges never coincide. This range covers both a clock faster than the limit by a wide margin and one close to it. Directed cases cover reset with and without the monitored clock, long outages that test saturation, and recovery timing.

// File: rtl/clk_loss_pkg.sv
`timescale 1ns/1ps
package clk_loss_pkg;

    // Default build values shared by the detector and its checker
    localparam int unsigned DEF_SYNC_STAGES = 2;
    localparam int unsigned DEF_IDLE_LIMIT  = 16;

    // Width needed to hold the values 0..limit
    function automatic int unsigned cnt_width(input int unsigned limit);
        return $clog2(limit + 1);
    endfunction

endpackage

// File: rtl/mon_toggle.sv
`timescale 1ns/1ps
module mon_toggle (
    input  logic mon_clk,
    input  logic rst_n,
    output logic tog_o
);
    logic tog_q;

    // Inverts on every monitored rising edge; the only logic in that domain
    always_ff @(posedge mon_clk or negedge rst_n) begin
        if (!rst_n) tog_q <= 1'b0;
        else        tog_q <= ~tog_q;
    end

    assign tog_o = tog_q;
endmodule

// File: rtl/bit_sync.sv
`timescale 1ns/1ps
module bit_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] chain_q;

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q[0] <= 1'b0;
                else        chain_q[0] <= d_i;
            end
        end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q[g] <= 1'b0;
                else        chain_q[g] <= chain_q[g-1];
            end
        end
    end

    assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/idle_timer.sv
`timescale 1ns/1ps
module idle_timer #(
    parameter int unsigned LIMIT = clk_loss_pkg::DEF_IDLE_LIMIT,
    localparam int unsigned CNT_W = clk_loss_pkg::cnt_width(LIMIT)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tog_s_i,
    output logic             act_o,
    output logic [CNT_W-1:0] cnt_o,
    output logic             lost_o
);
    localparam logic [CNT_W-1:0] CNT_TOP  = CNT_W'(LIMIT);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(LIMIT - 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             prev;
        logic             lost;
    } timer_state_t;

    timer_state_t st_d, st_q;
    logic         act;

    always_comb begin
        act       = tog_s_i ^ st_q.prev;
        st_d      = st_q;
        st_d.prev = tog_s_i;
        if (act) begin
            st_d.cnt  = '0;
            st_d.lost = 1'b0;
        end else if (st_q.cnt >= CNT_TOP) begin
            st_d.cnt  = CNT_TOP;
            st_d.lost = 1'b1;
        end else begin
            st_d.cnt  = st_q.cnt + 1'b1;
            st_d.lost = (st_q.cnt == CNT_LAST);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.cnt  <= CNT_TOP;
            st_q.prev <= 1'b0;
            st_q.lost <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign act_o  = act;
    assign cnt_o  = st_q.cnt;
    assign lost_o = st_q.lost;
endmodule

// File: rtl/clk_loss_detect.sv
`timescale 1ns/1ps
module clk_loss_detect #(
    parameter int unsigned SYNC_STAGES = clk_loss_pkg::DEF_SYNC_STAGES,
    parameter int unsigned IDLE_LIMIT  = clk_loss_pkg::DEF_IDLE_LIMIT,
    localparam int unsigned CNT_W = clk_loss_pkg::cnt_width(IDLE_LIMIT)
) (
    input  logic ref_clk,
    input  logic rst_n,
    input  logic mon_clk,
    output logic clk_lost
);
    logic             tog_raw;
    logic             tog_sync;
    logic             activity;
    logic [CNT_W-1:0] idle_cnt;

    mon_toggle u_tog (
        .mon_clk (mon_clk),
        .rst_n   (rst_n),
        .tog_o   (tog_raw)
    );

    bit_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (ref_clk),
        .rst_n (rst_n),
        .d_i   (tog_raw),
        .q_o   (tog_sync)
    );

    idle_timer #(.LIMIT(IDLE_LIMIT)) u_timer (
        .clk     (ref_clk),
        .rst_n   (rst_n),
        .tog_s_i (tog_sync),
        .act_o   (activity),
        .cnt_o   (idle_cnt),
        .lost_o  (clk_lost)
    );
endmodule

// File: rtl/clk_loss_checker.sv
`timescale 1ns/1ps
module clk_loss_checker #(
    parameter int unsigned LIMIT = clk_loss_pkg::DEF_IDLE_LIMIT,
    localparam int unsigned CNT_W = clk_loss_pkg::cnt_width(LIMIT)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             act,
    input logic [CNT_W-1:0] cnt,
    input logic             lost
);
    a_r4_hold_while_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (lost && !act) |=> lost);

    a_r5_clear_after_act: assert property (@(posedge clk) disable iff (!rst_n)
        act |=> !lost);

    a_r3_onset_at_limit: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lost) |-> ($past(cnt) == CNT_W'(LIMIT - 1)));

    a_r4_fall_needs_act: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(lost) |-> $past(act));

    a_r4_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CNT_W'(LIMIT));
endmodule

bind clk_loss_detect clk_loss_checker #(.LIMIT(IDLE_LIMIT)) u_chk (
    .clk   (ref_clk),
    .rst_n (rst_n),
    .act   (activity),
    .cnt   (idle_cnt),
    .lost  (clk_lost)
);

// File: tb/sim_clk_loss_detect.sv
`timescale 1ns/1ps
module sim_clk_loss_detect;
    localparam real REF_PER = 20.0;

    logic ref_clk = 1'b0;
    logic rst_n   = 1'b0;
    logic mon_clk = 1'b0;
    logic clk_lost;

    logic mon_en  = 1'b0;
    real  mon_half = 50.3;
    real  last_rise = 0.0;
    int   n_run  = 0;
    int   n_fail = 0;
    bit   done   = 1'b0;

    clk_loss_detect u0 (
        .ref_clk  (ref_clk),
        .rst_n    (rst_n),
        .mon_clk  (mon_clk),
        .clk_lost (clk_lost)
    );

    always #(REF_PER/2) ref_clk = ~ref_clk;

    initial begin
        forever begin
            wait (mon_en);
            #(mon_half) mon_clk = 1'b1;
            last_rise = $realtime;
            #(mon_half) mon_clk = 1'b0;
        end
    end

    function automatic bit onset_ok(input real cyc);
        return (cyc >= 9.0) && (cyc <= 21.0);
    endfunction

    task automatic check(input string req, input bit ok, input string act, input string exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%s expected=%s", req, act, exp);
        end
    endtask

    task automatic stop_mon();
        mon_en = 1'b0;
        #(2.0*mon_half + 1.0);
    endtask

    task automatic apply_reset(input bit clk_on);
        @(negedge ref_clk);
        rst_n = 1'b0;
        mon_en = clk_on;
        repeat (3) @(negedge ref_clk);
        check("R1", clk_lost === 1'b1, $sformatf("%b", clk_lost), "1 in reset");
        rst_n = 1'b1;
        @(negedge ref_clk);
        check("R1", clk_lost === 1'b1, $sformatf("%b", clk_lost), "1 after reset");
    endtask

    // R3: measure onset from the last monitored rising edge
    task automatic measure_loss(input string tag);
        real cyc;
        stop_mon();
        for (int i = 0; i < 40 && clk_lost !== 1'b1; i++) @(negedge ref_clk);
        cyc = ($realtime - last_rise) / REF_PER;
        check(tag, clk_lost === 1'b1 && onset_ok(cyc),
              $sformatf("lost=%b after %0.2f cycles", clk_lost, cyc), "1 within 9..21");
    endtask

    // R5: resume and time the clear
    task automatic measure_clear();
        int waited = 0;
        real t0;
        mon_en = 1'b1;
        @(posedge mon_clk);
        t0 = $realtime;
        while (clk_lost !== 1'b0 && waited < 20) begin
            @(negedge ref_clk);
            waited++;
        end
        check("R5", clk_lost === 1'b0 && ($realtime - t0) <= 5.0*REF_PER,
              $sformatf("lost=%b after %0.2f cycles", clk_lost, ($realtime - t0)/REF_PER),
              "0 within 5");
    endtask

    task automatic run_steady(input int cycles);
        bit seen = 1'b0;
        for (int i = 0; i < cycles; i++) begin
            @(negedge ref_clk);
            if (clk_lost !== 1'b0) seen = 1'b1;
        end
        check("R2", !seen, $sformatf("seen=%b half=%0.1f", seen, mon_half), "stays 0");
    endtask

    initial begin
        void'($urandom(32'd1357));

        // R1: no monitored clock, status stays up
        apply_reset(1'b0);
        begin
            bit dropped = 1'b0;
            for (int i = 0; i < 60; i++) begin
                @(negedge ref_clk);
                if (clk_lost !== 1'b1) dropped = 1'b1;
            end
            check("R1", !dropped, $sformatf("dropped=%b", dropped), "held at 1");
        end

        // R5: first activity clears the status
        mon_half = 50.3;
        measure_clear();

        // R2 / R3 random periods between 2 and 10 reference periods
        for (int k = 0; k < 8; k++) begin
            mon_half = real'(20 + ($urandom % 81)) + 0.3;
            mon_en = 1'b1;
            repeat (4) @(posedge mon_clk);
            @(negedge ref_clk);
            run_steady(150);
            measure_loss("R3");
            measure_clear();
        end

        // directed: fastest and slowest edge of the range
        mon_half = 20.3;
        run_steady(100);
        measure_loss("R3");
        mon_half = 99.7;
        measure_clear();
        repeat (3) @(posedge mon_clk);
        run_steady(200);
        measure_loss("R3");

        // R4: long outage, counter saturates, status holds
        begin
            bit dropped = 1'b0;
            for (int i = 0; i < 300; i++) begin
                @(negedge ref_clk);
                if (clk_lost !== 1'b1) dropped = 1'b1;
            end
            check("R4", !dropped, $sformatf("dropped=%b", dropped), "held at 1");
        end
        mon_half = 40.3;
        measure_clear();

        // R6: reset released with clock running
        apply_reset(1'b1);
        begin
            int w = 0;
            while (clk_lost !== 1'b0 && w < 20) begin
                @(negedge ref_clk);
                w++;
            end
            check("R6", clk_lost === 1'b0 && w <= 6, $sformatf("lost=%b w=%0d", clk_lost, w),
                  "0 within 6");
        end
        run_steady(100);

        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        #(200000.0 * REF_PER);
        if (!done) begin
            done = 1'b1;
            n_run++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule